// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock

This block is a real-time clock that counts seconds. It has a bus-side file of 16-bit registers and a timing core that advances only on cycles where a slow tick enable is high. The core holds a 20-bit reload value and a down-counting divider. Each time the divider reaches zero it reloads and advances a 32-bit seconds counter. The counter is compared against a 32-bit alarm. The block raises three sticky event flags (second, alarm, wrap-around), and each flag has its own interrupt enable.

Software can change the reload value, the counter and the alarm only while a configuration bit is set. Values written in that window are held in shadow registers. They move into the timing core on the first tick after software clears the configuration bit. A transfer-idle status bit reads 0 until that move has happened. A resync flag is cleared by software and set again by the next tick, which tells software that the readable copies are current. The bus is a plain single-cycle register port: writes take effect on the clock edge, and reads are combinational from the address. There is no back-pressure at either edge of the block.

Register word addresses: 0 interrupt enables, 1 control/status, 2 reload high, 3 reload low, 4 divider high, 5 divider low, 6 counter high, 7 counter low, 8 alarm high, 9 alarm low.

Top module: `rtcb_top`

## Requirements
- R1: After reset, the counter and reload read 0, both alarm halves read 0xFFFF, the enable register reads 0 and the control/status register reads 0x0020 (transfer-idle set, everything else clear).
- R2: Each 32-bit quantity reads as a high word (bits 31:16) and a low word (bits 15:0). The reload high word and the divider high word keep only bits 3:0, and their upper 12 bits read 0.
- R3: Writes to the reload, counter or alarm words made while the configuration bit (control bit 4) is 0 are ignored.
- R4: A control write that clears the configuration bit while it is set starts a transfer, and transfer-idle (control bit 5) reads 0. On the next tick, only the words written during the configuration window load into the core, the divider restarts from the reload value, and transfer-idle returns to 1.
- R5: On a tick with no transfer, the divider counts down by one. When it is already 0, it reloads and the counter increments, so the counter advances once every reload+1 ticks.
- R6: With the tick enable low, the counter and divider hold their values.
- R7: The second flag (control bit 0) is set on every divider reload.
- R8: The alarm flag (control bit 1) is set when the counter steps to a value equal to the alarm.
- R9: The wrap flag (control bit 2) is set when the counter steps from 0xFFFFFFFF to 0.
- R10: Writing 0 to an event flag bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clear wins.
- R11: The resync flag (control bit 3) clears when software writes 0 to it and is set by the next tick.
- R12: Each interrupt output is high exactly when its flag and its enable are both set. The enables are bit 0 for second, bit 1 for alarm and bit 2 for wrap.
- R13: The current divider value is readable through the divider high and low words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Slow tick; the core advances on cycles where it is high |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq_sec | output | 1 | Second interrupt |
| irq_alr | output | 1 | Alarm interrupt |
| irq_ovf | output | 1 | Wrap interrupt |

## Verification
The counting path is first run with a reload of 3, a counter start of 5 and an alarm of 7. This pattern separates the divider steps from the counter steps and shows that the alarm matches on the stepped value and not the old one. A second load places the counter at its maximum with a reload of 0, so every tick reloads; this isolates the wrap flag from the alarm compare. Writes made outside the configuration window, a flag clear in the same cycle as an event, and a reload high word written with all ones each distinguish a gated or masked design from one that lets the value through. Idle stretches with the tick low show whether anything moves without a tick.

// File: rtl/rtcb_pkg.sv
package rtcb_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_IEN  = 4'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd1;
  localparam logic [ADDR_W-1:0] A_PRLH = 4'd2;
  localparam logic [ADDR_W-1:0] A_PRLL = 4'd3;
  localparam logic [ADDR_W-1:0] A_DIVH = 4'd4;
  localparam logic [ADDR_W-1:0] A_DIVL = 4'd5;
  localparam logic [ADDR_W-1:0] A_CNTH = 4'd6;
  localparam logic [ADDR_W-1:0] A_CNTL = 4'd7;
  localparam logic [ADDR_W-1:0] A_ALRH = 4'd8;
  localparam logic [ADDR_W-1:0] A_ALRL = 4'd9;

  localparam int B_SECF  = 0;
  localparam int B_ALRF  = 1;
  localparam int B_OVFF  = 2;
  localparam int B_RSF   = 3;
  localparam int B_CFG   = 4;
  localparam int B_IDLE  = 5;

  typedef struct packed {
    logic sec;
    logic alr;
    logic ovf;
  } rtcb_evt_t;
endpackage

// File: rtl/rtcb_core.sv
module rtcb_core #(
  parameter int PRL_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic             ld_prl,
  input  logic             ld_cnt,
  input  logic             ld_alr,
  input  logic [PRL_W-1:0] sh_prl,
  input  logic [CNT_W-1:0] sh_cnt,
  input  logic [CNT_W-1:0] sh_alr,
  output logic [PRL_W-1:0] prl_q,
  output logic [PRL_W-1:0] div_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] alr_q,
  output rtcb_pkg::rtcb_evt_t evt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             step;
  logic [CNT_W-1:0] cnt_nx;

  assign step   = tick && !load && (div_q == '0);
  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    evt.sec = step;
    evt.ovf = step && (cnt_q == CNT_MAX);
    evt.alr = step && (cnt_nx == alr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prl_q <= '0;
      div_q <= '0;
      cnt_q <= '0;
      alr_q <= CNT_MAX;
    end else if (tick) begin
      if (load) begin
        if (ld_prl) prl_q <= sh_prl;
        if (ld_cnt) cnt_q <= sh_cnt;
        if (ld_alr) alr_q <= sh_alr;
        div_q <= ld_prl ? sh_prl : prl_q;
      end else if (div_q == '0) begin
        div_q <= prl_q;
        cnt_q <= cnt_nx;
      end else begin
        div_q <= div_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtcb_regs.sv
module rtcb_regs #(
  parameter int PRL_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             bus_we,
  input  logic [3:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  input  rtcb_pkg::rtcb_evt_t evt,
  input  logic [PRL_W-1:0] prl_q,
  input  logic [PRL_W-1:0] div_q,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic [CNT_W-1:0] alr_q,
  output logic             pending,
  output logic             ld_prl,
  output logic             ld_cnt,
  output logic             ld_alr,
  output logic [PRL_W-1:0] sh_prl,
  output logic [CNT_W-1:0] sh_cnt,
  output logic [CNT_W-1:0] sh_alr,
  output rtcb_pkg::rtcb_evt_t flags,
  output rtcb_pkg::rtcb_evt_t ien
);
  import rtcb_pkg::*;

  localparam int HI_W = PRL_W - REG_W;
  localparam int CH_W = CNT_W - REG_W;

  logic cfg_q, rsf_q;
  logic wr_ctrl, gate, xfer_start, xfer_done;

  assign wr_ctrl    = bus_we && (bus_addr == A_CTRL);
  assign gate       = bus_we && cfg_q;
  assign xfer_start = wr_ctrl && cfg_q && !bus_wdata[B_CFG];
  assign xfer_done  = tick && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= 1'b0;
      rsf_q   <= 1'b0;
      pending <= 1'b0;
      flags   <= '0;
      ien     <= '0;
    end else begin
      if (wr_ctrl) cfg_q <= bus_wdata[B_CFG];
      if (bus_we && bus_addr == A_IEN) begin
        ien.sec <= bus_wdata[0];
        ien.alr <= bus_wdata[1];
        ien.ovf <= bus_wdata[2];
      end
      rsf_q     <= (rsf_q && !(wr_ctrl && !bus_wdata[B_RSF])) || tick;
      flags.sec <= (flags.sec && !(wr_ctrl && !bus_wdata[B_SECF])) || evt.sec;
      flags.alr <= (flags.alr && !(wr_ctrl && !bus_wdata[B_ALRF])) || evt.alr;
      flags.ovf <= (flags.ovf && !(wr_ctrl && !bus_wdata[B_OVFF])) || evt.ovf;
      if (xfer_start)     pending <= 1'b1;
      else if (xfer_done) pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_prl <= '0;
      sh_cnt <= '0;
      sh_alr <= '1;
      ld_prl <= 1'b0;
      ld_cnt <= 1'b0;
      ld_alr <= 1'b0;
    end else begin
      if (xfer_done) begin
        ld_prl <= 1'b0;
        ld_cnt <= 1'b0;
        ld_alr <= 1'b0;
      end
      if (gate) begin
        unique case (bus_addr)
          A_PRLH: begin sh_prl[PRL_W-1:REG_W] <= bus_wdata[HI_W-1:0]; ld_prl <= 1'b1; end
          A_PRLL: begin sh_prl[REG_W-1:0]     <= bus_wdata;           ld_prl <= 1'b1; end
          A_CNTH: begin sh_cnt[CNT_W-1:REG_W] <= bus_wdata[CH_W-1:0]; ld_cnt <= 1'b1; end
          A_CNTL: begin sh_cnt[REG_W-1:0]     <= bus_wdata;           ld_cnt <= 1'b1; end
          A_ALRH: begin sh_alr[CNT_W-1:REG_W] <= bus_wdata[CH_W-1:0]; ld_alr <= 1'b1; end
          A_ALRL: begin sh_alr[REG_W-1:0]     <= bus_wdata;           ld_alr <= 1'b1; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_IEN:  bus_rdata[2:0] = {ien.ovf, ien.alr, ien.sec};
      A_CTRL: begin
        bus_rdata[B_SECF] = flags.sec;
        bus_rdata[B_ALRF] = flags.alr;
        bus_rdata[B_OVFF] = flags.ovf;
        bus_rdata[B_RSF]  = rsf_q;
        bus_rdata[B_CFG]  = cfg_q;
        bus_rdata[B_IDLE] = !pending;
      end
      A_PRLH: bus_rdata[HI_W-1:0] = prl_q[PRL_W-1:REG_W];
      A_PRLL: bus_rdata           = prl_q[REG_W-1:0];
      A_DIVH: bus_rdata[HI_W-1:0] = div_q[PRL_W-1:REG_W];
      A_DIVL: bus_rdata           = div_q[REG_W-1:0];
      A_CNTH: bus_rdata[CH_W-1:0] = cnt_q[CNT_W-1:REG_W];
      A_CNTL: bus_rdata           = cnt_q[REG_W-1:0];
      A_ALRH: bus_rdata[CH_W-1:0] = alr_q[CNT_W-1:REG_W];
      A_ALRL: bus_rdata           = alr_q[REG_W-1:0];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtcb_top.sv
module rtcb_top #(
  parameter int PRL_W = 20,
  parameter int CNT_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq_sec,
  output logic        irq_alr,
  output logic        irq_ovf
);
  logic             xfer_pend, ld_prl, ld_cnt, ld_alr;
  logic [PRL_W-1:0] sh_prl, core_prl, core_div;
  logic [CNT_W-1:0] sh_cnt, sh_alr, core_cnt, core_alr;
  rtcb_pkg::rtcb_evt_t evt, flags, ien;

  rtcb_core #(.PRL_W(PRL_W), .CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .load(xfer_pend),
    .ld_prl(ld_prl), .ld_cnt(ld_cnt), .ld_alr(ld_alr),
    .sh_prl(sh_prl), .sh_cnt(sh_cnt), .sh_alr(sh_alr),
    .prl_q(core_prl), .div_q(core_div), .cnt_q(core_cnt), .alr_q(core_alr),
    .evt(evt)
  );

  rtcb_regs #(.PRL_W(PRL_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt(evt), .prl_q(core_prl), .div_q(core_div), .cnt_q(core_cnt), .alr_q(core_alr),
    .pending(xfer_pend), .ld_prl(ld_prl), .ld_cnt(ld_cnt), .ld_alr(ld_alr),
    .sh_prl(sh_prl), .sh_cnt(sh_cnt), .sh_alr(sh_alr),
    .flags(flags), .ien(ien)
  );

  assign irq_sec = flags.sec && ien.sec;
  assign irq_alr = flags.alr && ien.alr;
  assign irq_ovf = flags.ovf && ien.ovf;
endmodule

// File: rtl/rtcb_chk.sv
module rtcb_chk #(
  parameter int PRL_W = 20,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_en,
  input logic             pend,
  input logic             ld_cnt,
  input logic [CNT_W-1:0] sh_cnt,
  input logic [PRL_W-1:0] div,
  input logic [CNT_W-1:0] cnt,
  input logic             secf
);
  p_div_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !pend && div != '0) |=> div == $past(div) - 1'b1);

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !pend && div == '0) |=> cnt == $past(cnt) + 1'b1);

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(cnt) && $stable(div)));

  p_load_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && pend && ld_cnt) |=> (cnt == $past(sh_cnt) && !pend));

  p_secf_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(secf) |-> $past(tick_en));
endmodule

bind rtcb_top rtcb_chk #(.PRL_W(PRL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .pend(xfer_pend),
  .ld_cnt(ld_cnt), .sh_cnt(sh_cnt), .div(core_div), .cnt(core_cnt),
  .secf(flags.sec)
);

// File: tb/rtcb_top_bench.sv
module rtcb_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_sec, irq_alr, irq_ovf;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtcb_top u_rtcb_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alr(irq_alr), .irq_ovf(irq_ovf)
  );

  // entry: {op[1:0], addr[3:0], value[15:0], req[7:0]}; op 0 write, 1 read check, 2 ticks
  localparam int NV = 27;
  localparam logic [29:0] VEC [NV] = '{
    {2'd0, 4'd1, 16'h0010, 8'd4},  // R4 enter configuration
    {2'd0, 4'd2, 16'h0000, 8'd4},
    {2'd0, 4'd3, 16'h0003, 8'd4},
    {2'd0, 4'd6, 16'h0000, 8'd4},
    {2'd0, 4'd7, 16'h0005, 8'd4},
    {2'd0, 4'd8, 16'h0000, 8'd4},
    {2'd0, 4'd9, 16'h0007, 8'd4},
    {2'd0, 4'd1, 16'h0000, 8'd4},  // R4 leave configuration
    {2'd1, 4'd1, 16'h0000, 8'd4},  // R4 transfer-idle low
    {2'd2, 4'd0, 16'd1,    8'd4},
    {2'd1, 4'd1, 16'h0028, 8'd11}, // R11 resync set by tick
    {2'd1, 4'd7, 16'h0005, 8'd4},
    {2'd1, 4'd5, 16'h0003, 8'd13}, // R13 divider readable
    {2'd1, 4'd9, 16'h0007, 8'd2},  // R2 low alarm word
    {2'd2, 4'd0, 16'd3,    8'd5},
    {2'd1, 4'd5, 16'h0000, 8'd5},  // R5 divider at zero
    {2'd1, 4'd7, 16'h0005, 8'd5},
    {2'd2, 4'd0, 16'd1,    8'd5},
    {2'd1, 4'd7, 16'h0006, 8'd5},  // R5 step after reload+1 ticks
    {2'd1, 4'd1, 16'h0029, 8'd7},  // R7 second flag
    {2'd2, 4'd0, 16'd4,    8'd8},
    {2'd1, 4'd7, 16'h0007, 8'd8},
    {2'd1, 4'd1, 16'h002B, 8'd8},  // R8 alarm flag
    {2'd0, 4'd7, 16'h0100, 8'd3},  // R3 write outside configuration
    {2'd1, 4'd7, 16'h0007, 8'd3},
    {2'd0, 4'd1, 16'h0008, 8'd10}, // R10 clear flags, keep resync
    {2'd1, 4'd1, 16'h0028, 8'd10}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [3:0] a, input logic [15:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1 chk(req, bus_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 4'd1, 16'h0020);
    rd("R1", 4'd0, 16'h0000);
    rd("R1", 4'd6, 16'h0000);
    rd("R1", 4'd7, 16'h0000);
    rd("R1", 4'd3, 16'h0000);
    rd("R1", 4'd8, 16'hFFFF);
    rd("R1", 4'd9, 16'hFFFF);

    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = $sformatf("R%0d", VEC[k][7:0]);
      case (VEC[k][29:28])
        2'd0: wr(VEC[k][27:24], VEC[k][23:8]);
        2'd1: rd(tag, VEC[k][27:24], VEC[k][23:8]);
        default: ticks(int'(VEC[k][23:8]));
      endcase
    end

    // R9 wrap: reload 0, counter at maximum, alarm untouched
    wr(4'd1, 16'h0018);
    wr(4'd3, 16'h0000);
    wr(4'd6, 16'hFFFF);
    wr(4'd7, 16'hFFFF);
    wr(4'd1, 16'h0008);
    ticks(1);
    rd("R9", 4'd6, 16'hFFFF);
    rd("R9", 4'd1, 16'h0028);
    ticks(1);
    rd("R9", 4'd6, 16'h0000);
    rd("R9", 4'd7, 16'h0000);
    rd("R9", 4'd1, 16'h002D);

    // R12 interrupt gating
    wr(4'd0, 16'h0004);
    #1 chk("R12 ovf", {15'd0, irq_ovf}, 16'd1);
    chk("R12 sec", {15'd0, irq_sec}, 16'd0);
    chk("R12 alr", {15'd0, irq_alr}, 16'd0);
    wr(4'd0, 16'h0001);
    #1 chk("R12 sec", {15'd0, irq_sec}, 16'd1);
    chk("R12 ovf", {15'd0, irq_ovf}, 16'd0);

    // R10 clear and event in the same cycle: event wins
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd1; bus_wdata = 16'h0008; tick_en = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; tick_en = 1'b0;
    rd("R10", 4'd1, 16'h0029);

    // R11 resync clear then set
    wr(4'd1, 16'h0000);
    rd("R11", 4'd1, 16'h0020);
    ticks(1);
    rd("R11", 4'd1, 16'h0029);

    // R6 no movement without tick
    rd("R6", 4'd7, 16'h0002);
    repeat (20) @(negedge clk);
    rd("R6", 4'd7, 16'h0002);
    rd("R6", 4'd5, 16'h0000);

    // R2 reload high word masked to four bits
    wr(4'd1, 16'h0018);
    wr(4'd2, 16'hFFFF);
    wr(4'd3, 16'h0002);
    wr(4'd1, 16'h0008);
    ticks(1);
    rd("R2", 4'd2, 16'h000F);
    rd("R2", 4'd3, 16'h0002);
    rd("R2", 4'd4, 16'h000F);
    rd("R2", 4'd5, 16'h0002);
    rd("R2", 4'd7, 16'h0002);

    finish_run();
  end
endmodule